// File: doc/BRIEF.md
# Sync-Prefixed Command Frame Responder

This block sits between a byte-wide UART (configured for 8 data bits, no parity, one stop bit, 9600 baud) and the rest of a controller. It watches the incoming byte stream for two-byte command frames: a sync byte of value 0xFF, then one command code. Once a complete frame is seen, it begins its reply on the very next cycle and needs no further input to do so.

The command class decides the reply. A known control code gets a single acknowledge byte. A known query code gets a length byte followed by a fixed block of parameter bytes from a small bank that the surrounding logic supplies. An unknown code gets a negative-acknowledge byte. Known commands also raise a one-cycle decoded-command strobe that carries the code, so local logic can act on it. The host may repeat a frame whenever a reply looks wrong, so the responder is ready for a new frame as soon as a reply is complete.

Top module: `cmd_responder`

## Requirements
- R1: After reset, tx_valid and cmd_pulse are low and the responder is waiting for a sync byte.
- R2: While waiting for sync, any received byte other than 0xFF is discarded and produces no reply and no pulse.
- R3: When the byte after a sync is not 0xFF, tx_valid rises in the cycle after that byte is accepted.
- R4: A 0xFF received where a command code is expected counts as a new sync, and the responder keeps waiting for the code.
- R5: A control code (bit 7 clear, value below NUM_CTRL, default 4) is answered with exactly one byte, ACK_BYTE (default 0x06).
- R6: A query code (bit 7 set, bits 6:0 = group g below NUM_QUERY, default 2) is answered with the length byte PARAM_BYTES (default 4), then bytes g*PARAM_BYTES+0 .. g*PARAM_BYTES+PARAM_BYTES-1 of param_bank in that order, byte i being param_bank[8*i+7:8*i].
- R7: Any other code (not 0xFF) is answered with exactly one byte, NAK_BYTE (default 0x15), and cmd_pulse stays low.
- R8: For a known code, cmd_pulse is high for exactly one cycle, in the same cycle as the first reply byte, and cmd_code then equals the received code.
- R9: While tx_valid is high and tx_ready is low, tx_data holds its value. A byte counts as sent only on a cycle with both high.
- R10: Bytes received while a reply is pending are ignored, including during the cycle of the last byte's handshake. A fresh frame is accepted from the cycle after that handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte strobe from the UART |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | UART can take a byte this cycle |
| tx_valid | output | 1 | Reply byte is offered |
| tx_data | output | 8 | Reply byte |
| param_bank | input | NUM_QUERY*PARAM_BYTES*8 | Parameter bytes, byte i at bits 8*i+7:8*i |
| cmd_pulse | output | 1 | One-cycle strobe for a decoded known command |
| cmd_code | output | 8 | Code of the decoded command |

## Verification
The last handshake of a reply and the arrival of a new received byte can fall in the same cycle. The bench provokes this by driving a 0xFF sync byte in exactly that cycle, then sending a lone control code. The responder must stay silent, because the sync had to be dropped, and a full frame sent straight afterwards must be answered at once. The strobe and the first reply byte also coincide, and this is judged on every code of a full sweep over all command values, with and without stalls on tx_ready.

// File: rtl/cmdr_pkg.sv
package cmdr_pkg;

  typedef enum logic [0:0] {FR_HUNT, FR_CODE} frame_st_e;
  typedef enum logic [1:0] {RK_ACK, RK_NAK, RK_QUERY} reply_kind_e;

  localparam logic [7:0] SYNC_BYTE = 8'hFF;

  function automatic logic is_query(input logic [7:0] code);
    return code[7];
  endfunction

  function automatic logic code_known(input logic [7:0] code, input int n_ctrl,
                                      input int n_query);
    if (code[7]) return int'(code[6:0]) < n_query;
    return int'(code[6:0]) < n_ctrl;
  endfunction

  function automatic int reply_len(input logic [7:0] code, input int n_ctrl,
                                   input int n_query, input int pbytes);
    if (code_known(code, n_ctrl, n_query) && is_query(code)) return pbytes + 1;
    return 1;
  endfunction

endpackage

// File: rtl/cmdr_frame_fsm.sv
module cmdr_frame_fsm
  import cmdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       busy,
  output logic       frame_hit,
  output logic [7:0] frame_code
);

  frame_st_e st_q;
  logic      rx_take;

  assign rx_take    = rx_valid && !busy;
  assign frame_hit  = (st_q == FR_CODE) && rx_take && (rx_data != SYNC_BYTE);
  assign frame_code = rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= FR_HUNT;
    end else if (rx_take) begin
      case (st_q)
        FR_HUNT: if (rx_data == SYNC_BYTE) st_q <= FR_CODE;
        default: if (rx_data != SYNC_BYTE) st_q <= FR_HUNT;
      endcase
    end
  end

  AST_RX_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rx_valid |=> $stable(st_q)); // R10

  AST_HUNT_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_HUNT) && rx_take && (rx_data != SYNC_BYTE) |=> (st_q == FR_HUNT)); // R2

  AST_REPEAT_SYNC_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_CODE) && rx_take && (rx_data == SYNC_BYTE) |=> (st_q == FR_CODE)); // R4

endmodule

// File: rtl/cmdr_reply_gen.sv
module cmdr_reply_gen
  import cmdr_pkg::*;
#(
  parameter int         NUM_CTRL    = 4,
  parameter int         NUM_QUERY   = 2,
  parameter int         PARAM_BYTES = 4,
  parameter logic [7:0] ACK_BYTE    = 8'h06,
  parameter logic [7:0] NAK_BYTE    = 8'h15
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                frame_hit,
  input  logic [7:0]                          frame_code,
  input  logic [NUM_QUERY*PARAM_BYTES*8-1:0]  param_bank,
  input  logic                                tx_ready,
  output logic                                busy,
  output logic                                tx_valid,
  output logic [7:0]                          tx_data,
  output logic                                cmd_pulse,
  output logic [7:0]                          cmd_code
);

  localparam int BANK_BYTES = NUM_QUERY * PARAM_BYTES;
  localparam int IDX_W      = $clog2(PARAM_BYTES + 1);
  localparam int GRP_W      = (NUM_QUERY > 1) ? $clog2(NUM_QUERY) : 1;
  localparam int SEL_W      = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1;

  logic [7:0]       bank_b [BANK_BYTES];
  reply_kind_e      kind_q;
  logic [GRP_W-1:0] grp_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q, pulse_q;
  logic [7:0]       code_q;
  logic             last_byte, tx_fire;
  logic [SEL_W-1:0] sel;

  for (genvar i = 0; i < BANK_BYTES; i++) begin : g_bank
    assign bank_b[i] = param_bank[8*i +: 8];
  end

  assign busy      = busy_q;
  assign tx_valid  = busy_q;
  assign cmd_pulse = pulse_q;
  assign cmd_code  = code_q;
  assign tx_fire   = busy_q && tx_ready;
  assign last_byte = (kind_q != RK_QUERY) || (idx_q == IDX_W'(PARAM_BYTES));

  always_comb begin
    sel = '0;
    case (kind_q)
      RK_ACK:  tx_data = ACK_BYTE;
      RK_NAK:  tx_data = NAK_BYTE;
      default: begin
        if (idx_q == '0) begin
          tx_data = 8'(PARAM_BYTES);
        end else begin
          sel     = SEL_W'(int'(grp_q) * PARAM_BYTES + int'(idx_q) - 1);
          tx_data = bank_b[sel];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
      kind_q  <= RK_ACK;
      grp_q   <= '0;
      idx_q   <= '0;
      code_q  <= '0;
    end else begin
      pulse_q <= 1'b0;
      if (!busy_q) begin
        if (frame_hit) begin
          busy_q  <= 1'b1;
          idx_q   <= '0;
          code_q  <= frame_code;
          pulse_q <= code_known(frame_code, NUM_CTRL, NUM_QUERY);
          if (!code_known(frame_code, NUM_CTRL, NUM_QUERY)) begin
            kind_q <= RK_NAK;
          end else if (is_query(frame_code)) begin
            kind_q <= RK_QUERY;
            grp_q  <= GRP_W'(frame_code[6:0]);
          end else begin
            kind_q <= RK_ACK;
          end
        end
      end else if (tx_fire) begin
        if (last_byte) busy_q <= 1'b0;
        else           idx_q  <= idx_q + 1'b1;
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse |=> !cmd_pulse); // R8

  AST_PULSE_STARTS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse |-> $rose(tx_valid)); // R8

  AST_REPLY_FOLLOWS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(frame_hit)); // R3

  AST_NAK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) && (tx_data == NAK_BYTE) |-> !cmd_pulse); // R7

endmodule

// File: rtl/cmd_responder.sv
module cmd_responder
  import cmdr_pkg::*;
#(
  parameter int         NUM_CTRL    = 4,
  parameter int         NUM_QUERY   = 2,
  parameter int         PARAM_BYTES = 4,
  parameter logic [7:0] ACK_BYTE    = 8'h06,
  parameter logic [7:0] NAK_BYTE    = 8'h15
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rx_valid,
  input  logic [7:0]                         rx_data,
  input  logic                               tx_ready,
  output logic                               tx_valid,
  output logic [7:0]                         tx_data,
  input  logic [NUM_QUERY*PARAM_BYTES*8-1:0] param_bank,
  output logic                               cmd_pulse,
  output logic [7:0]                         cmd_code
);

  logic       busy;
  logic       frame_hit;
  logic [7:0] frame_code;

  cmdr_frame_fsm i_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .busy      (busy),
    .frame_hit (frame_hit),
    .frame_code(frame_code)
  );

  cmdr_reply_gen #(
    .NUM_CTRL   (NUM_CTRL),
    .NUM_QUERY  (NUM_QUERY),
    .PARAM_BYTES(PARAM_BYTES),
    .ACK_BYTE   (ACK_BYTE),
    .NAK_BYTE   (NAK_BYTE)
  ) i_reply (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_hit (frame_hit),
    .frame_code(frame_code),
    .param_bank(param_bank),
    .tx_ready  (tx_ready),
    .busy      (busy),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .cmd_pulse (cmd_pulse),
    .cmd_code  (cmd_code)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> !tx_valid && !cmd_pulse); // R1

  AST_PULSE_CODE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse |-> (cmd_code != SYNC_BYTE)); // R8

endmodule

// File: tb/test_cmd_responder.sv
`timescale 1ns/1ps
module test_cmd_responder;

  localparam int NC = 4, NQ = 2, PB = 4;
  localparam logic [7:0] ACK = 8'h06, NAK = 8'h15;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_valid = 1'b0;
  logic [7:0]       rx_data = '0;
  logic             tx_ready = 1'b0;
  logic             tx_valid;
  logic [7:0]       tx_data;
  logic [NQ*PB*8-1:0] param_bank;
  logic             cmd_pulse;
  logic [7:0]       cmd_code;

  int tests = 0, fails = 0;
  logic [7:0] got [8];
  int n_got;
  int exp_len;
  logic [7:0] expb [8];

  always #2.5 clk = ~clk;

  cmd_responder i_cmd_responder (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .param_bank(param_bank), .cmd_pulse(cmd_pulse), .cmd_code(cmd_code)
  );

  function automatic logic [7:0] bank_byte(input int i);
    return 8'(8'h30 + 7 * i);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // Collects a reply; optionally stalls tx_ready and optionally drives a sync
  // byte in the cycle of the last handshake.
  task automatic run_reply(input bit stall, input bit poke_last);
    int cyc = 0;
    logic [7:0] prev = '0;
    bit prev_stall = 0;
    n_got = 0;
    while (tx_valid && cyc < 60) begin
      bit rdy = stall ? (cyc % 3 != 1) : 1'b1;
      if (prev_stall) chk(tx_data == prev, "R9 hold", tx_data, prev);
      if (cyc > 0) chk(cmd_pulse == 1'b0, "R8 single", cmd_pulse, 0);
      if (rdy && n_got < 8) begin
        got[n_got] = tx_data;
        n_got++;
      end
      if (rdy && poke_last && n_got == exp_len) begin
        rx_valid = 1'b1;
        rx_data  = 8'hFF;
      end
      prev = tx_data;
      prev_stall = !rdy;
      tx_ready = rdy;
      @(negedge clk);
      tx_ready = 1'b0;
      rx_valid = 1'b0;
      cyc++;
    end
  endtask

  task automatic build_expect(input logic [7:0] c, output bit known);
    bit q = c[7];
    known = q ? (int'(c[6:0]) < NQ) : (int'(c[6:0]) < NC);
    if (!known) begin
      exp_len = 1; expb[0] = NAK;
    end else if (!q) begin
      exp_len = 1; expb[0] = ACK;
    end else begin
      exp_len = PB + 1;
      expb[0] = 8'(PB);
      for (int k = 0; k < PB; k++) expb[k+1] = bank_byte(int'(c[6:0]) * PB + k);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit known;
    for (int i = 0; i < NQ * PB; i++) param_bank[8*i +: 8] = bank_byte(i);
    repeat (3) @(negedge clk);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(cmd_pulse == 1'b0, "R1 cmd_pulse", cmd_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_valid == 1'b0, "R1 idle", tx_valid, 0);

    // R2: stray bytes without sync
    send_byte(8'h01);
    chk(tx_valid == 1'b0, "R2 stray 01", tx_valid, 0);
    send_byte(8'h80);
    chk(tx_valid == 1'b0, "R2 stray 80", tx_valid, 0);
    send_byte(8'h33);
    chk(cmd_pulse == 1'b0, "R2 no pulse", cmd_pulse, 0);

    // R4: repeated sync before code
    send_byte(8'hFF);
    send_byte(8'hFF);
    chk(tx_valid == 1'b0, "R4 waits", tx_valid, 0);
    send_byte(8'hFF);
    send_byte(8'h02);
    chk(tx_valid == 1'b1, "R4 reply", tx_valid, 1);
    chk(tx_data == ACK, "R4 ack", tx_data, ACK);
    exp_len = 1;
    run_reply(0, 0);

    // Sweep of all codes: R3 R5 R6 R7 R8 R9
    for (int c = 0; c < 255; c++) begin
      build_expect(8'(c), known);
      send_byte(8'hFF);
      send_byte(8'(c));
      chk(tx_valid == 1'b1, "R3 start", tx_valid, 1);
      chk(cmd_pulse == known, known ? "R8 pulse" : "R7 no pulse", cmd_pulse, known);
      if (known) chk(cmd_code == 8'(c), "R8 code", cmd_code, c);
      run_reply(c[0], 0);
      chk(n_got == exp_len, c[7] ? "R6 length" : "R5 R7 length", n_got, exp_len);
      for (int k = 0; k < exp_len && k < n_got; k++)
        chk(got[k] == expb[k], !known ? "R7 byte" : (c[7] ? "R6 byte" : "R5 byte"),
            got[k], expb[k]);
      chk(tx_valid == 1'b0, "R5 R6 end", tx_valid, 0);
    end

    // R10: sync during last handshake is dropped
    send_byte(8'hFF);
    send_byte(8'h01);
    exp_len = 1;
    run_reply(0, 1);
    send_byte(8'h01);
    chk(tx_valid == 1'b0, "R10 dropped sync", tx_valid, 0);
    @(negedge clk);
    chk(tx_valid == 1'b0, "R10 still idle", tx_valid, 0);
    send_byte(8'hFF);
    send_byte(8'h81);
    chk(tx_valid == 1'b1, "R10 fresh frame", tx_valid, 1);
    build_expect(8'h81, known);
    run_reply(1, 0);
    chk(n_got == exp_len, "R10 reply len", n_got, exp_len);
    // bytes during a reply are ignored
    send_byte(8'hFF);
    send_byte(8'h00);
    exp_len = 1;
    rx_valid = 1'b1; rx_data = 8'hFF;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h03;
    @(negedge clk);
    rx_valid = 1'b0;
    run_reply(0, 0);
    chk(n_got == 1, "R10 busy ignore len", n_got, 1);
    @(negedge clk);
    chk(tx_valid == 1'b0, "R10 busy ignore", tx_valid, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule